// File: doc/BRIEF.md
# Asynchronous DRAM Read Sequencer

This block turns single-word read requests into the strobe sequence that a classic asynchronous DRAM with a multiplexed address bus expects. A request carries a row address, a column address and a read-style bit. The sequencer puts the row on the shared address pins and lowers the row strobe. It then switches the pins to the column and lowers the column strobe. It lowers output enable either before or after the column strobe. It samples the returned word once every access-time limit has passed.

All DRAM timing limits are parameters counted in system clock cycles. They are meant to be derived from nanosecond figures by rounding up to the clock period. The row stays open after a read. A later request to the same row runs as a page-mode column access and leaves the row strobe low. A request to another row raises the row strobe and waits out the row-cycle limit before it opens the new row. Write enable is held inactive, since the block only reads.

Top module: `dram_read_seq`

## Requirements
- R1: During and right after reset, the row strobe, column strobe, write enable and output enable are high, `rd_valid` is low and `req_ready` is high.
- R2: A row opens as follows. The row address is on `mem_addr` the cycle before the row strobe falls and stays there through the fall. The column address is driven from the cycle after the row strobe falls. The column strobe falls no sooner than two cycles after the row strobe, with the column address stable on the pins. The column strobe and output enable are only ever low while the row strobe is low.
- R3: Two falling edges of the row strobe are at least `T_RC` cycles apart.
- R4: Two falling edges of the column strobe are at least `T_PC` cycles apart.
- R5: The data word is sampled at the first clock edge that is at least `T_RAC` cycles after the row strobe fell, at least `T_CAC` cycles after the column strobe fell and at least `T_OE` cycles after output enable fell. At that same edge, `rd_valid` is raised for exactly one cycle with the sampled word on `rd_data`, and both the column strobe and output enable return high.
- R6: With `req_late_oe` = 0 (early style), output enable falls in the cycle the column address is first driven, before the column strobe. With `req_late_oe` = 1 (late style), output enable falls exactly one cycle after the column strobe.
- R7: A request to the row that is currently open leaves the row strobe low. Its column strobe falls at the later of one cycle after acceptance and the column-cycle limit.
- R8: A request to a different row raises the row strobe at the acceptance edge. The new row then opens at the later of one cycle after acceptance and `T_RC` cycles after the previous row strobe fall.
- R9: Write enable stays high at all times.
- R10: `req_ready` is high only while no access is in progress. A request is accepted at a rising edge where both `req_valid` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_late_oe | input | 1 | 0: early output-enable read, 1: late output-enable read |
| req_ready | output | 1 | Sequencer can accept a request |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low, held high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_dq | input | DATA_W | Data pins from the DRAM |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a read word |
| rd_data | output | DATA_W | Word sampled from the DRAM |

## Verification
The bench reads from a closed row first, then from the same row back to back, so that the column-cycle limit decides when the column strobe falls. It then reads another row right after a read, so that the row-cycle limit decides when the row reopens. Each of these is repeated after idle gaps, where neither limit has any effect. Both read styles are mixed in, so the bench tells the timing rules apart from the fixed one- and two-cycle setup steps, and an early-style read from a late-style one. The memory model drives a wrong word on the data pins whenever any access time has not yet been met, so a sample taken one edge too early shows up as a data mismatch as well as a timing mismatch.

// File: rtl/dram_read_seq.sv
module dram_read_seq #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 16,
  parameter int T_RAC  = 6,
  parameter int T_CAC  = 2,
  parameter int T_RC   = 11,
  parameter int T_PC   = 4,
  parameter int T_OE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_late_oe,
  output logic              req_ready,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int A_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LIM = T_RC + T_RAC + T_CAC + T_PC + T_OE;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] C_LIM = CW'(LIM);
  localparam logic [CW-1:0] C_RAC = CW'(T_RAC);
  localparam logic [CW-1:0] C_CAC = CW'(T_CAC);
  localparam logic [CW-1:0] C_RC  = CW'(T_RC);
  localparam logic [CW-1:0] C_PC  = CW'(T_PC);
  localparam logic [CW-1:0] C_OE  = CW'(T_OE);
  localparam logic [CW-1:0] C_ONE = CW'(1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSET, ST_RHOLD, ST_CSET, ST_CAS, ST_OPEN
  } state_t;

  state_t            state;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              late_q;
  logic [CW-1:0]     ras_el, cas_el, oe_el;
  logic              data_ok;

  assign req_ready = (state == ST_IDLE) || (state == ST_OPEN);
  assign mem_we_n  = 1'b1;
  assign data_ok   = !mem_oe_n && (ras_el >= C_RAC) && (cas_el >= C_CAC) && (oe_el >= C_OE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      late_q    <= 1'b0;
      mem_ras_n <= 1'b1;
      mem_cas_n <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_addr  <= '0;
      ras_el    <= C_LIM;
      cas_el    <= C_LIM;
      oe_el     <= C_LIM;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      ras_el   <= (ras_el == C_LIM) ? C_LIM : ras_el + C_ONE;
      cas_el   <= (cas_el == C_LIM) ? C_LIM : cas_el + C_ONE;
      oe_el    <= (oe_el  == C_LIM) ? C_LIM : oe_el  + C_ONE;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            row_q    <= req_row;
            col_q    <= req_col;
            late_q   <= req_late_oe;
            mem_addr <= A_W'(req_row);
            state    <= ST_RSET;
          end
        end
        ST_OPEN: begin
          if (req_valid) begin
            col_q  <= req_col;
            late_q <= req_late_oe;
            if (req_row == row_q) begin
              mem_addr <= A_W'(req_col);
              if (!req_late_oe) begin
                mem_oe_n <= 1'b0;
                oe_el    <= C_ONE;
              end
              state <= ST_CSET;
            end else begin
              row_q     <= req_row;
              mem_ras_n <= 1'b1;
              mem_addr  <= A_W'(req_row);
              state     <= ST_RSET;
            end
          end
        end
        ST_RSET: begin
          if (ras_el >= C_RC) begin
            mem_ras_n <= 1'b0;
            ras_el    <= C_ONE;
            state     <= ST_RHOLD;
          end
        end
        ST_RHOLD: begin
          mem_addr <= A_W'(col_q);
          if (!late_q) begin
            mem_oe_n <= 1'b0;
            oe_el    <= C_ONE;
          end
          state <= ST_CSET;
        end
        ST_CSET: begin
          if (cas_el >= C_PC) begin
            mem_cas_n <= 1'b0;
            cas_el    <= C_ONE;
            state     <= ST_CAS;
          end
        end
        ST_CAS: begin
          if (late_q && mem_oe_n) begin
            mem_oe_n <= 1'b0;
            oe_el    <= C_ONE;
          end else if (data_ok) begin
            rd_data   <= mem_dq;
            rd_valid  <= 1'b1;
            mem_cas_n <= 1'b1;
            mem_oe_n  <= 1'b1;
            state     <= ST_OPEN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_read_seq_chk.sv
module dram_read_seq_chk #(
  parameter int A_W   = 11,
  parameter int T_RAC = 6,
  parameter int T_CAC = 2,
  parameter int T_RC  = 11,
  parameter int T_PC  = 4,
  parameter int T_OE  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ras_n,
  input logic           cas_n,
  input logic           oe_n,
  input logic [A_W-1:0] addr,
  input logic           rd_valid
);
  localparam int LIM = T_RC + T_RAC + T_CAC + T_PC + T_OE;

  logic p_ras, p_cas, p_oe;
  int   ras_gap, cas_gap, oe_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_ras   <= 1'b1;
      p_cas   <= 1'b1;
      p_oe    <= 1'b1;
      ras_gap <= LIM;
      cas_gap <= LIM;
      oe_gap  <= LIM;
    end else begin
      p_ras   <= ras_n;
      p_cas   <= cas_n;
      p_oe    <= oe_n;
      ras_gap <= (p_ras && !ras_n) ? 1 : ((ras_gap < LIM) ? ras_gap + 1 : LIM);
      cas_gap <= (p_cas && !cas_n) ? 1 : ((cas_gap < LIM) ? cas_gap + 1 : LIM);
      oe_gap  <= (p_oe  && !oe_n)  ? 1 : ((oe_gap  < LIM) ? oe_gap  + 1 : LIM);
    end
  end

  AST_ROW_ADDR_HELD:  assert property (@(posedge clk) disable iff (!rst_n) (p_ras && !ras_n) |-> $stable(addr)); // R2
  AST_COL_ADDR_HELD:  assert property (@(posedge clk) disable iff (!rst_n) (p_cas && !cas_n) |-> $stable(addr)); // R2
  AST_CAS_IN_ROW:     assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R2
  AST_OE_IN_ROW:      assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !ras_n); // R2
  AST_ROW_CYCLE:      assert property (@(posedge clk) disable iff (!rst_n) (p_ras && !ras_n) |-> ras_gap >= T_RC); // R3
  AST_PAGE_CYCLE:     assert property (@(posedge clk) disable iff (!rst_n) (p_cas && !cas_n) |-> cas_gap >= T_PC); // R4
  AST_DATA_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> ras_gap >= T_RAC); // R5
  AST_DATA_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> cas_gap >= T_CAC); // R5
  AST_DATA_AFTER_OE:  assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> oe_gap >= T_OE); // R5
  AST_STROBES_FREED:  assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (cas_n && oe_n)); // R5
  AST_SINGLE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R5
endmodule

bind dram_read_seq dram_read_seq_chk #(
  .A_W(A_W), .T_RAC(T_RAC), .T_CAC(T_CAC), .T_RC(T_RC), .T_PC(T_PC), .T_OE(T_OE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(mem_ras_n), .cas_n(mem_cas_n),
  .oe_n(mem_oe_n), .addr(mem_addr), .rd_valid(rd_valid)
);

// File: tb/dram_read_seq_bench.sv
module dram_read_seq_bench;
  localparam int CLK_NS = 10;
  localparam int ROW_W  = 11;
  localparam int COL_W  = 11;
  localparam int DATA_W = 16;
  localparam int T_RAC  = 6;
  localparam int T_CAC  = 2;
  localparam int T_RC   = 11;
  localparam int T_PC   = 5;
  localparam int T_OE   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              req_late_oe = 1'b0;
  logic              req_ready;
  logic              mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n;
  logic [10:0]       mem_addr;
  logic [DATA_W-1:0] mem_dq = '0;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;

  dram_read_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RAC(T_RAC),
    .T_CAC(T_CAC), .T_RC(T_RC), .T_PC(T_PC), .T_OE(T_OE)
  ) u_dram_read_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_col(req_col), .req_late_oe(req_late_oe), .req_ready(req_ready),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int ec     = 0;
  always @(posedge clk) ec <= ec + 1;

  int   ras_f = -1000, ras_r = -1000, cas_f = -1000, oe_f = -1000;
  logic [10:0] ras_addr = '0, cas_addr = '0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_oe = 1'b1, p_rdv = 1'b0;
  int   we_bad = 0, strobe_bad = 0, pulse_bad = 0;
  bit   rd_seen = 0;
  int   rd_edge = 0;
  logic [DATA_W-1:0] rd_word = '0;
  bit   open_ok = 0;
  logic [ROW_W-1:0] open_row = '0;

  function automatic logic [15:0] word_of(input logic [10:0] r, input logic [10:0] c);
    return {r[7:0] ^ 8'hA5, c[7:0] ^ {5'b0, r[10:8]}};
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // DRAM model and port monitor, evaluated mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !mem_ras_n) begin ras_f = ec; ras_addr = mem_addr; end
      if (!p_ras && mem_ras_n) ras_r = ec;
      if (p_cas && !mem_cas_n) begin cas_f = ec; cas_addr = mem_addr; end
      if (p_oe && !mem_oe_n) oe_f = ec;
      if (mem_we_n !== 1'b1) we_bad++;
      if ((!mem_cas_n || !mem_oe_n) && mem_ras_n) strobe_bad++;
      if (rd_valid && (p_rdv || !mem_cas_n || !mem_oe_n)) pulse_bad++;
      if (rd_valid) begin rd_seen = 1; rd_edge = ec; rd_word = rd_data; end
      p_ras = mem_ras_n; p_cas = mem_cas_n; p_oe = mem_oe_n; p_rdv = rd_valid;
    end
    if (!mem_ras_n && !mem_cas_n && !mem_oe_n &&
        (ec + 1 - ras_f >= T_RAC) && (ec + 1 - cas_f >= T_CAC) && (ec + 1 - oe_f >= T_OE))
      mem_dq = word_of(ras_addr, cas_addr);
    else
      mem_dq = 16'hBAD0 ^ ec[15:0];
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ras_n in reset", mem_ras_n, 1);
    chk("R1 cas_n in reset", mem_cas_n, 1);
    chk("R1 oe_n in reset", mem_oe_n, 1);
    chk("R1 we_n in reset", mem_we_n, 1);
    chk("R1 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 ras_n after reset", mem_ras_n, 1);
  endtask

  task automatic do_read(input logic [10:0] row, input logic [10:0] col, input bit late, input string name);
    int a, prev_ras, prev_cas, exp_ras, exp_cas, exp_oe, exp_cap;
    bit hit;
    while (!req_ready) begin @(negedge clk); #1; end
    hit      = open_ok && (row == open_row);
    prev_ras = ras_f;
    prev_cas = cas_f;
    rd_seen  = 0;
    req_valid = 1'b1; req_row = row; req_col = col; req_late_oe = late;
    @(negedge clk); #1;
    a = ec;
    req_valid = 1'b0;
    chk({name, " R10 busy after accept"}, req_ready, 0);
    while (!rd_seen) begin @(negedge clk); #1; end
    if (hit) begin
      chk({name, " R7 row strobe not reopened"}, ras_f, prev_ras);
      exp_cas = max2(a + 1, prev_cas + T_PC);
      chk({name, " R4 R7 column strobe edge"}, cas_f, exp_cas);
      exp_oe = a;
    end else begin
      exp_ras = max2(a + 1, prev_ras + T_RC);
      if (open_ok) chk({name, " R8 row closed at accept"}, ras_r, a);
      chk({name, " R3 R8 row strobe edge"}, ras_f, exp_ras);
      chk({name, " R2 row address at strobe"}, int'(ras_addr), int'(row));
      exp_cas = max2(ras_f + 2, prev_cas + T_PC);
      chk({name, " R2 R4 column strobe edge"}, cas_f, exp_cas);
      exp_oe = ras_f + 1;
    end
    chk({name, " R2 column address at strobe"}, int'(cas_addr), int'(col));
    if (late) chk({name, " R6 late output enable"}, oe_f, cas_f + 1);
    else      chk({name, " R6 early output enable"}, oe_f, exp_oe);
    exp_cap = max2(max2(ras_f + T_RAC, cas_f + T_CAC), oe_f + T_OE);
    chk({name, " R5 capture edge"}, rd_edge, exp_cap);
    chk({name, " R5 data word"}, int'(rd_word), int'(word_of(row, col)));
    chk({name, " R10 ready after read"}, req_ready, 1);
    open_ok  = 1;
    open_row = row;
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    do_read(11'h012, 11'h034, 1'b0, "closed_early");
    do_read(11'h012, 11'h035, 1'b0, "hit_early");
    do_read(11'h012, 11'h036, 1'b1, "hit_late_pc_bound");
    do_read(11'h2A5, 11'h007, 1'b0, "miss_early");
    do_read(11'h3C1, 11'h0F0, 1'b1, "miss_late_rc_bound");
    do_read(11'h3C1, 11'h7FF, 1'b1, "hit_late_maxcol");
    repeat (30) @(negedge clk);
    do_read(11'h3C1, 11'h001, 1'b0, "hit_after_idle");
    repeat (30) @(negedge clk);
    do_read(11'h7FF, 11'h000, 1'b1, "miss_after_idle");
    do_read(11'h000, 11'h555, 1'b0, "miss_row_zero");
    chk("R9 write enable stayed high", we_bad, 0);
    chk("R2 strobes only inside open row", strobe_bad, 0);
    chk("R5 single pulse with strobes released", pulse_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule